// File: doc/BRIEF.md
# Hardware Cursor Colour and Configuration Unit

This block sits between a hardware cursor's image fetch and the panel output mux. It holds the cursor's settings in a small bank of 32-bit registers that software can write and read. The bank has a configuration word, two 24-bit colour entries and a cursor position word. The position word carries the X and Y coordinates and an image index. Each cycle a 2-bit cursor pixel code comes in. The block turns it into a panel colour, or into a transparent or inverted flag for the downstream mixer. The colour is trimmed to the bits the selected panel mode can show.

Software writes the cursor position into a shadow copy. The active position, which the pixel pipeline uses, is loaded from that shadow in one of two ways. In immediate mode it is loaded at once. In frame-synchronised mode it is loaded only at the next frame-sync pulse, so the cursor never tears halfway through a frame. The size bit selects a 32x32 cursor with four images, or a single 64x64 image.

Top module: `cursor_color_unit`

## Requirements
- R1: After reset, every register reads zero, the active position and image index are zero, and all pixel outputs are low.
- R2: Register 0 is the configuration word. Bit 0 selects the size (0 = 32x32, 1 = 64x64) and bit 1 selects deferred position update (1 = wait for frame sync). Bits 31:2 always read 0, and writes to them are ignored.
- R3: Registers 1 and 2 are colour entries A and B. Red is in bits 7:0, Green in bits 15:8 and Blue in bits 23:16. Bits 31:24 read 0, and writes to them are ignored.
- R4: Register 3 is the shadow position. X is in bits 11:0, Y in bits 27:16 and the image index in bits 31:30. Reads return the shadow value. The cur_img output shows the active index in 32x32 mode and is 0 in 64x64 mode.
- R5: The pixel outputs are registered one cycle after pix_valid and pix_code. Code 0 outputs colour A and code 1 outputs colour B, each with color_valid high. Code 2 raises only transparent and code 3 raises only invert, each with rgb 0. When pix_valid is low, all flags and rgb are 0.
- R6: With panel_mode 0 (monochrome STN), only rgb bits 7:4 (upper Red nibble) may be nonzero.
- R7: With panel_mode 1 (colour STN), only the upper nibble of each channel passes (rgb mask 0xF0F0F0).
- R8: With panel_mode 2 or 3 (24 bpp), all 24 colour bits pass.
- R9: In immediate mode, a position write shows on cur_x, cur_y and cur_img in the cycle after the write.
- R10: In deferred mode, the active position does not change until a frame_sync pulse. The pulse then loads the latest shadow value.
- R11: In deferred mode, a position write in the same cycle as frame_sync does not take effect on that pulse. It takes effect on the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| frame_sync | input | 1 | Frame-sync pulse |
| pix_valid | input | 1 | Cursor pixel present |
| pix_code | input | 2 | Cursor pixel code |
| panel_mode | input | 2 | Panel colour mode |
| cur_x | output | 12 | Active X coordinate |
| cur_y | output | 12 | Active Y coordinate |
| cur_img | output | 2 | Active image index |
| out_rgb | output | 24 | Trimmed cursor colour |
| out_color_valid | output | 1 | rgb holds a cursor colour |
| out_transparent | output | 1 | Pixel is transparent |
| out_invert | output | 1 | Pixel inverts the background |

## Verification
The bench sweeps every pixel code against every panel mode with several colour patterns. A wrong trim mask would leak low nibbles, or Green and Blue on a monochrome panel. Swapped entries would show colour B for code 0. The bench writes all-ones to both registers and checks that the reserved bits read back zero, which a bank that stored full words would fail. For position timing it checks three cases: an immediate write appearing one cycle later, a deferred write held across idle cycles, and a write that coincides with the pulse. A design that transfers on that same edge would show the new coordinates one frame early. It also checks that the image index is forced to zero in 64x64 mode.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    localparam logic [1:0] REG_CFG  = 2'd0;
    localparam logic [1:0] REG_COLA = 2'd1;
    localparam logic [1:0] REG_COLB = 2'd2;
    localparam logic [1:0] REG_POS  = 2'd3;

    typedef enum logic [1:0] {
        PIX_COLA   = 2'd0,
        PIX_COLB   = 2'd1,
        PIX_CLEAR  = 2'd2,
        PIX_INVERT = 2'd3
    } pix_code_e;

    typedef enum logic [1:0] {
        PANEL_MONO  = 2'd0,
        PANEL_CSTN  = 2'd1,
        PANEL_FULL  = 2'd2,
        PANEL_FULL2 = 2'd3
    } panel_mode_e;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int COORD_W = 12,
    parameter int CH_W    = 8,
    parameter int IMG_W   = 2,
    parameter int Y_LSB   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic                 frame_sync,
    output logic                 size_big,
    output logic                 sync_mode,
    output logic [3*CH_W-1:0]    col_a,
    output logic [3*CH_W-1:0]    col_b,
    output logic [COORD_W-1:0]   act_x,
    output logic [COORD_W-1:0]   act_y,
    output logic [IMG_W-1:0]     act_img
);
    localparam int COL_W = 3 * CH_W;

    typedef struct packed {
        logic [IMG_W-1:0]   img;
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] x;
    } pos_t;

    typedef struct packed {
        logic             size;
        logic             sync;
        logic [COL_W-1:0] cola;
        logic [COL_W-1:0] colb;
        pos_t             shadow;
        pos_t             active;
        logic             pend;
    } state_t;

    state_t st_d, st_q;
    pos_t   wr_pos;
    logic   pos_wr;
    logic   unused_wbits;

    assign unused_wbits = ^wdata;

    always_comb begin
        wr_pos.x   = wdata[COORD_W-1:0];
        wr_pos.y   = wdata[Y_LSB +: COORD_W];
        wr_pos.img = wdata[DATA_W-1 -: IMG_W];
        pos_wr     = wr_en && (addr == REG_POS);
        st_d       = st_q;
        if (wr_en) begin
            case (addr)
                REG_CFG: begin
                    st_d.size = wdata[0];
                    st_d.sync = wdata[1];
                end
                REG_COLA: st_d.cola   = wdata[COL_W-1:0];
                REG_COLB: st_d.colb   = wdata[COL_W-1:0];
                default:  st_d.shadow = wr_pos;
            endcase
        end
        if (pos_wr && !st_q.sync) begin
            st_d.active = wr_pos;
            st_d.pend   = 1'b0;
        end else if (pos_wr) begin
            st_d.pend   = 1'b1;
        end else if (frame_sync && st_q.pend) begin
            st_d.active = st_q.shadow;
            st_d.pend   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_CFG: begin
                rdata[0] = st_q.size;
                rdata[1] = st_q.sync;
            end
            REG_COLA: rdata[COL_W-1:0] = st_q.cola;
            REG_COLB: rdata[COL_W-1:0] = st_q.colb;
            default: begin
                rdata[COORD_W-1:0]        = st_q.shadow.x;
                rdata[Y_LSB +: COORD_W]   = st_q.shadow.y;
                rdata[DATA_W-1 -: IMG_W]  = st_q.shadow.img;
            end
        endcase
    end

    assign size_big  = st_q.size;
    assign sync_mode = st_q.sync;
    assign col_a     = st_q.cola;
    assign col_b     = st_q.colb;
    assign act_x     = st_q.active.x;
    assign act_y     = st_q.active.y;
    assign act_img   = st_q.size ? '0 : st_q.active.img;
endmodule

// File: rtl/cursor_pix.sv
module cursor_pix
    import cursor_pkg::*;
#(
    parameter int CH_W = 8,
    parameter int KEEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic [1:0]        pix_code,
    input  logic [1:0]        panel_mode,
    input  logic [3*CH_W-1:0] col_a,
    input  logic [3*CH_W-1:0] col_b,
    output logic [3*CH_W-1:0] rgb,
    output logic              color_valid,
    output logic              transparent,
    output logic              invert
);
    localparam int COL_W = 3 * CH_W;
    localparam logic [CH_W-1:0] TOP_NIB = {{KEEP{1'b1}}, {(CH_W-KEEP){1'b0}}};

    typedef struct packed {
        logic [COL_W-1:0] rgb;
        logic             cval;
        logic             clr;
        logic             inv;
    } out_t;

    out_t o_d, o_q;
    logic [COL_W-1:0] mono_mask, cstn_mask, mask, picked;

    for (genvar c = 0; c < 3; c++) begin : g_mask
        assign mono_mask[c*CH_W +: CH_W] = (c == 0) ? TOP_NIB : '0;
        assign cstn_mask[c*CH_W +: CH_W] = TOP_NIB;
    end

    always_comb begin
        case (panel_mode_e'(panel_mode))
            PANEL_MONO: mask = mono_mask;
            PANEL_CSTN: mask = cstn_mask;
            default:    mask = '1;
        endcase
        picked = (pix_code == PIX_COLB) ? col_b : col_a;
        o_d    = '0;
        if (pix_valid) begin
            case (pix_code_e'(pix_code))
                PIX_COLA, PIX_COLB: begin
                    o_d.rgb  = picked & mask;
                    o_d.cval = 1'b1;
                end
                PIX_CLEAR: o_d.clr = 1'b1;
                default:   o_d.inv = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign rgb         = o_q.rgb;
    assign color_valid = o_q.cval;
    assign transparent = o_q.clr;
    assign invert      = o_q.inv;
endmodule

// File: rtl/cursor_color_unit.sv
module cursor_color_unit #(
    parameter int DATA_W  = 32,
    parameter int COORD_W = 12,
    parameter int CH_W    = 8,
    parameter int IMG_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                frame_sync,
    input  logic                pix_valid,
    input  logic [1:0]          pix_code,
    input  logic [1:0]          panel_mode,
    output logic [COORD_W-1:0]  cur_x,
    output logic [COORD_W-1:0]  cur_y,
    output logic [IMG_W-1:0]    cur_img,
    output logic [3*CH_W-1:0]   out_rgb,
    output logic                out_color_valid,
    output logic                out_transparent,
    output logic                out_invert
);
    logic              size_big_w, sync_mode_w;
    logic [3*CH_W-1:0] col_a_w, col_b_w;

    cursor_regs #(
        .DATA_W(DATA_W), .COORD_W(COORD_W), .CH_W(CH_W), .IMG_W(IMG_W), .Y_LSB(16)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .frame_sync(frame_sync),
        .size_big(size_big_w), .sync_mode(sync_mode_w),
        .col_a(col_a_w), .col_b(col_b_w),
        .act_x(cur_x), .act_y(cur_y), .act_img(cur_img)
    );

    cursor_pix #(.CH_W(CH_W), .KEEP(4)) u_pix (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_code(pix_code),
        .panel_mode(panel_mode), .col_a(col_a_w), .col_b(col_b_w),
        .rgb(out_rgb), .color_valid(out_color_valid),
        .transparent(out_transparent), .invert(out_invert)
    );
endmodule

// File: rtl/cursor_chk.sv
module cursor_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        frame_sync,
    input logic        sync_mode_w,
    input logic        pix_valid,
    input logic [1:0]  panel_mode,
    input logic [11:0] cur_x,
    input logic [11:0] cur_y,
    input logic [1:0]  cur_img,
    input logic [23:0] out_rgb,
    input logic        out_color_valid,
    input logic        out_transparent,
    input logic        out_invert
);
    // R2
    cfg_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[31:2] == '0));

    // R3
    col_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd1 || reg_addr == 2'd2) |-> (reg_rdata[31:24] == '0));

    // R5
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_color_valid, out_transparent, out_invert}));

    // R5
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> (!out_color_valid && !out_transparent && !out_invert && out_rgb == '0));

    // R6
    mono_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && panel_mode == 2'd0) |=> (out_rgb[23:8] == '0 && out_rgb[3:0] == '0));

    // R4
    big_img_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[0]) |=> (cur_img == '0));

    // R10
    defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode_w && !frame_sync && !(reg_wr && reg_addr == 2'd0))
        |=> $stable({cur_img, cur_y, cur_x}));
endmodule

bind cursor_color_unit cursor_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_sync(frame_sync),
    .sync_mode_w(sync_mode_w), .pix_valid(pix_valid), .panel_mode(panel_mode),
    .cur_x(cur_x), .cur_y(cur_y), .cur_img(cur_img), .out_rgb(out_rgb),
    .out_color_valid(out_color_valid), .out_transparent(out_transparent),
    .out_invert(out_invert)
);

// File: tb/sim_cursor_color_unit.sv
module sim_cursor_color_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_sync = 1'b0;
    logic        pix_valid = 1'b0;
    logic [1:0]  pix_code = '0;
    logic [1:0]  panel_mode = '0;
    logic [11:0] cur_x, cur_y;
    logic [1:0]  cur_img;
    logic [23:0] out_rgb;
    logic        out_color_valid, out_transparent, out_invert;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cursor_color_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_sync(frame_sync),
        .pix_valid(pix_valid), .pix_code(pix_code), .panel_mode(panel_mode),
        .cur_x(cur_x), .cur_y(cur_y), .cur_img(cur_img), .out_rgb(out_rgb),
        .out_color_valid(out_color_valid), .out_transparent(out_transparent),
        .out_invert(out_invert)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse();
        @(negedge clk);
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
    endtask

    function automatic logic [23:0] trim(input logic [23:0] c, input int mode);
        if (mode == 0)      return c & 24'h0000F0;
        else if (mode == 1) return c & 24'hF0F0F0;
        else                return c;
    endfunction

    function automatic logic [31:0] pos_word(input int x, input int y, input int img);
        return (32'(img) << 30) | (32'(y) << 16) | 32'(x);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        logic [23:0] ca, cb, pats[3];
        pats[0] = 24'h123456; pats[1] = 24'hFFFFFF; pats[2] = 24'hA5C3E7;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            chk("R1 reg reset", r, 32'h0);
        end
        chk("R1 active pos reset", {cur_img, cur_y, cur_x}, 32'h0);
        chk("R1 pixel outputs reset", {out_color_valid, out_transparent, out_invert, out_rgb}, 32'h0);

        // R2 config reserved bits
        wr(2'd0, 32'hFFFF_FFFC);
        rd(2'd0, r);
        chk("R2 cfg reserved-only write", r, 32'h0);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, r);
        chk("R2 cfg all-ones", r, 32'h3);
        wr(2'd0, 32'h0);

        // R3 colour layout and reserved byte
        wr(2'd1, 32'hAB12_3456);
        rd(2'd1, r);
        chk("R3 colour A readback", r, 32'h0012_3456);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, r);
        chk("R3 colour B readback", r, 32'h00FF_FFFF);

        // R5 R6 R7 R8 pixel sweep
        for (int p = 0; p < 3; p++) begin
            ca = pats[p];
            cb = ~pats[p];
            wr(2'd1, {8'h00, ca});
            wr(2'd2, {8'h00, cb});
            for (int m = 0; m < 4; m++) begin
                for (int c = 0; c < 4; c++) begin
                    @(negedge clk);
                    pix_valid = 1'b1; pix_code = 2'(c); panel_mode = 2'(m);
                    @(negedge clk);
                    pix_valid = 1'b0;
                    if (c == 0)
                        chk("R5/R6/R7/R8 code0 colour", {out_color_valid, out_transparent, out_invert, out_rgb},
                            {3'b100, trim(ca, m)});
                    else if (c == 1)
                        chk("R5/R6/R7/R8 code1 colour", {out_color_valid, out_transparent, out_invert, out_rgb},
                            {3'b100, trim(cb, m)});
                    else if (c == 2)
                        chk("R5 transparent", {out_color_valid, out_transparent, out_invert, out_rgb},
                            {3'b010, 24'h0});
                    else
                        chk("R5 invert", {out_color_valid, out_transparent, out_invert, out_rgb},
                            {3'b001, 24'h0});
                end
            end
        end
        @(negedge clk);
        chk("R5 no pixel", {out_color_valid, out_transparent, out_invert, out_rgb}, 32'h0);

        // R9 immediate update
        wr(2'd3, pos_word(100, 200, 1));
        chk("R9 immediate position", {cur_img, cur_y, cur_x}, {2'd1, 12'd200, 12'd100});

        // R10 deferred update
        wr(2'd0, 32'h2);
        wr(2'd3, pos_word(300, 400, 3));
        chk("R10 held after write", {cur_img, cur_y, cur_x}, {2'd1, 12'd200, 12'd100});
        repeat (3) @(negedge clk);
        chk("R10 held over idle", {cur_img, cur_y, cur_x}, {2'd1, 12'd200, 12'd100});
        rd(2'd3, r);
        chk("R4 shadow readback", r, pos_word(300, 400, 3));
        pulse();
        chk("R10 loaded at sync", {cur_img, cur_y, cur_x}, {2'd3, 12'd400, 12'd300});

        // R11 write coincident with pulse
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = pos_word(4095, 7, 2); frame_sync = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; frame_sync = 1'b0;
        chk("R11 not taken on same pulse", {cur_img, cur_y, cur_x}, {2'd3, 12'd400, 12'd300});
        pulse();
        chk("R11 taken on next pulse", {cur_img, cur_y, cur_x}, {2'd2, 12'd7, 12'd4095});

        // R4 image index forced to zero in large mode
        wr(2'd0, 32'h3);
        chk("R4 image zero in 64x64", {30'h0, cur_img}, 32'h0);
        wr(2'd0, 32'h2);
        chk("R4 image back in 32x32", {30'h0, cur_img}, 32'h2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule